// File: doc/BRIEF.md
# Load-Use Hazard Stall Controller

This block watches the pipeline registers of a five-stage in-order integer pipeline. It decides when the instruction in decode must wait one cycle because forwarding cannot supply an operand in time. There are two such cases:

- A load in execute produces a register that the decode instruction reads.
- A branch resolved in decode needs a register that a load still in the memory stage is about to return.

When either case holds, the block holds the program counter and the fetch/decode register, and injects a bubble into the decode/execute register. The bubble is made by clearing the state-changing control fields, such as register write and memory write.

The decision is purely combinational from the present contents of the pipeline registers. The surrounding pipeline applies it at the next clock edge. After that edge the bubble occupies execute and the producing load has advanced one stage, so the condition clears without help and forwarding delivers the value. The block carries no data stream, so it has no valid/ready handshake. Every pin is a plain level signal and there is no back-pressure to obey.

Top module: `ldu_stall_ctrl`

## Requirements
- R1: When `ex_is_load` is 1, `ex_dst` is nonzero and `ex_dst` equals `dec_src_a`, a stall is requested in the same cycle.
- R2: When `ex_is_load` is 1, `ex_dst` is nonzero and `ex_dst` equals `dec_src_b`, a stall is requested in the same cycle.
- R3: When `dec_is_branch` is 1, `mem_is_load` is 1, `mem_dst` is nonzero and `mem_dst` equals either decode source, a stall is requested.
- R4: A load in the memory stage whose destination matches a decode source causes no stall when `dec_is_branch` is 0.
- R5: A producer destination of register 0 never causes a stall, whatever the flags and sources are.
- R6: A producer whose load flag is 0 never causes a stall, even when its destination matches a decode source.
- R7: A stall request is signalled as `pc_wr_en`=0, `fd_wr_en`=0 and `de_bubble`=1. With no stall the values are `pc_wr_en`=1, `fd_wr_en`=1 and `de_bubble`=0.
- R8: The outputs depend only on the current input values, with no registered state. A change of inputs that removes the hazard releases the stall within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src_a | input | REG_AW | First source register of the decode instruction |
| dec_src_b | input | REG_AW | Second source register of the decode instruction |
| dec_is_branch | input | 1 | Decode instruction is a conditional branch resolved in decode |
| ex_is_load | input | 1 | Execute-stage instruction reads data memory |
| ex_dst | input | REG_AW | Destination register of the execute-stage instruction |
| mem_is_load | input | 1 | Memory-stage instruction reads data memory |
| mem_dst | input | REG_AW | Destination register of the memory-stage instruction |
| pc_wr_en | output | 1 | Program counter update enable |
| fd_wr_en | output | 1 | Fetch/decode pipeline register update enable |
| de_bubble | output | 1 | Clear the control fields entering decode/execute |

## Verification
All three results are due zero cycles after a stimulus, because no register stands between the inputs and the outputs. The bench therefore drives a new input set shortly after a rising edge and samples the outputs half a period later, before the next edge. Each check compares the sampled outputs with a value computed by a bench function from the requirements. Back-to-back vectors that remove a hazard show that the release also occurs within the cycle, with nothing left over from the previous cycle.

// File: rtl/ldu_stall_pkg.sv
package ldu_stall_pkg;
  // default register address width (32 architectural registers)
  localparam int unsigned DEF_REG_AW = 5;
  // number of source operands read by a decode instruction
  localparam int unsigned SRC_PORTS  = 2;
endpackage

// File: rtl/ldu_src_cmp.sv
module ldu_src_cmp #(
  parameter int unsigned AW   = 5,
  parameter int unsigned NSRC = 2
) (
  input  logic                     prod_load,
  input  logic [AW-1:0]            prod_dst,
  input  logic [NSRC-1:0][AW-1:0]  srcs,
  output logic [NSRC-1:0]          src_hit,
  output logic                     any_hit
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic dst_live;
  assign dst_live = prod_load && (prod_dst != ZERO_REG);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign src_hit[i] = dst_live && (srcs[i] == prod_dst);
  end

  assign any_hit = |src_hit;

  always_comb begin
    // R5
    zero_dst_chk: assert (!(prod_dst == ZERO_REG && any_hit));
    // R6
    no_load_chk: assert (prod_load || !any_hit);
  end
endmodule

// File: rtl/ldu_stall_merge.sv
module ldu_stall_merge (
  input  logic ex_hit,
  input  logic mem_hit,
  input  logic branch,
  output logic pc_we,
  output logic fd_we,
  output logic bubble
);
  logic stall;
  // a load one stage further on only matters to a branch resolved in decode
  assign stall  = ex_hit || (branch && mem_hit);
  assign pc_we  = !stall;
  assign fd_we  = !stall;
  assign bubble = stall;

  always_comb begin
    // R4
    mem_needs_branch_chk: assert (ex_hit || branch || !bubble);
  end
endmodule

// File: rtl/ldu_stall_ctrl.sv
module ldu_stall_ctrl
  import ldu_stall_pkg::*;
#(
  parameter int unsigned REG_AW = DEF_REG_AW
) (
  input  logic [REG_AW-1:0] dec_src_a,
  input  logic [REG_AW-1:0] dec_src_b,
  input  logic              dec_is_branch,
  input  logic              ex_is_load,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              mem_is_load,
  input  logic [REG_AW-1:0] mem_dst,
  output logic              pc_wr_en,
  output logic              fd_wr_en,
  output logic              de_bubble
);
  localparam int unsigned NPROD = 2;  // producers: execute, memory

  logic [SRC_PORTS-1:0][REG_AW-1:0] dec_srcs;
  logic [NPROD-1:0]                 prod_load;
  logic [NPROD-1:0][REG_AW-1:0]     prod_dst;
  logic [NPROD-1:0]                 prod_hit;
  logic [NPROD-1:0][SRC_PORTS-1:0]  prod_src_hit;

  assign dec_srcs  = {dec_src_b, dec_src_a};
  assign prod_load = {mem_is_load, ex_is_load};
  assign prod_dst  = {mem_dst, ex_dst};

  for (genvar p = 0; p < NPROD; p++) begin : g_prod
    ldu_src_cmp #(.AW(REG_AW), .NSRC(SRC_PORTS)) u_cmp (
      .prod_load (prod_load[p]),
      .prod_dst  (prod_dst[p]),
      .srcs      (dec_srcs),
      .src_hit   (prod_src_hit[p]),
      .any_hit   (prod_hit[p])
    );
  end

  ldu_stall_merge u_merge (
    .ex_hit  (prod_hit[0]),
    .mem_hit (prod_hit[1]),
    .branch  (dec_is_branch),
    .pc_we   (pc_wr_en),
    .fd_we   (fd_wr_en),
    .bubble  (de_bubble)
  );

  always_comb begin
    // R1
    ex_src_a_chk: assert (!(ex_is_load && ex_dst != '0 && ex_dst == dec_src_a) || de_bubble);
    // R2
    ex_src_b_chk: assert (!(ex_is_load && ex_dst != '0 && ex_dst == dec_src_b) || de_bubble);
    // R3
    br_mem_chk: assert (!(dec_is_branch && mem_is_load && mem_dst != '0 &&
                          (mem_dst == dec_src_a || mem_dst == dec_src_b)) || de_bubble);
    // R7
    hold_vs_bubble_chk: assert (pc_wr_en == fd_wr_en && pc_wr_en != de_bubble);
  end
endmodule

// File: tb/tb_ldu_stall_ctrl.sv
`timescale 1ns/1ps
module tb_ldu_stall_ctrl;
  localparam int AW = 5;
  localparam int WATCHDOG = 5000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [AW-1:0] src_a, src_b, ex_d, mem_d;
  logic br, ex_ld, mem_ld;
  logic pc_we, fd_we, bub;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  ldu_stall_ctrl #(.REG_AW(AW)) dut (
    .dec_src_a(src_a), .dec_src_b(src_b), .dec_is_branch(br),
    .ex_is_load(ex_ld), .ex_dst(ex_d), .mem_is_load(mem_ld), .mem_dst(mem_d),
    .pc_wr_en(pc_we), .fd_wr_en(fd_we), .de_bubble(bub)
  );

  function automatic bit ex_rule(input logic [AW-1:0] a, b, d, input logic ld);
    return ld && d != 0 && (d == a || d == b);
  endfunction

  function automatic bit exp_stall();
    return ex_rule(src_a, src_b, ex_d, ex_ld) ||
           (br && ex_rule(src_a, src_b, mem_d, mem_ld));
  endfunction

  task automatic drive(input logic [AW-1:0] a, b, input logic brn,
                       input logic el, input logic [AW-1:0] ed,
                       input logic ml, input logic [AW-1:0] md);
    @(posedge clk);
    #1;
    src_a = a; src_b = b; br = brn; ex_ld = el; ex_d = ed; mem_ld = ml; mem_d = md;
    @(negedge clk);  // outputs are combinational: due in this same cycle
  endtask

  task automatic chk(input string req, input bit stall);
    logic [2:0] act, exp;
    act = {pc_we, fd_we, bub};
    exp = stall ? 3'b001 : 3'b110;
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {pc_wr_en,fd_wr_en,de_bubble} actual=%b expected=%b", req, act, exp);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2468));
    src_a = 0; src_b = 0; br = 0; ex_ld = 0; ex_d = 0; mem_ld = 0; mem_d = 0;
    // idle state: all zero inputs -> run (R7)
    drive(0, 0, 0, 0, 0, 0, 0);        chk("R7 idle", 0);
    drive(3, 4, 0, 1, 3, 0, 0);        chk("R1 ex load -> src_a", 1);
    drive(3, 4, 0, 1, 4, 0, 0);        chk("R2 ex load -> src_b", 1);
    drive(3, 4, 0, 1, 9, 0, 0);        chk("R1 ex load no match", 0);
    drive(7, 2, 1, 0, 0, 1, 7);        chk("R3 branch, mem load -> src_a", 1);
    drive(7, 2, 1, 0, 0, 1, 2);        chk("R3 branch, mem load -> src_b", 1);
    drive(7, 2, 0, 0, 0, 1, 7);        chk("R4 mem load, no branch", 0);
    drive(0, 0, 1, 1, 0, 1, 0);        chk("R5 dst zero both stages", 0);
    drive(0, 5, 0, 1, 0, 0, 0);        chk("R5 ex dst zero, src_a zero", 0);
    drive(6, 6, 1, 0, 6, 0, 6);        chk("R6 matches without load flag", 0);
    drive(31, 8, 1, 1, 31, 1, 8);      chk("R7 both hazards", 1);
    // R8: stall then immediate release in the next cycle, no memory
    drive(12, 1, 0, 1, 12, 0, 0);      chk("R8 stall cycle", 1);
    drive(12, 1, 0, 0, 0, 1, 12);      chk("R8 released next cycle", 0);
    drive(12, 1, 1, 0, 0, 1, 12);      chk("R8 reassert same cycle", 1);
    drive(12, 1, 1, 0, 0, 1, 13);      chk("R8 release on dst change", 0);

    for (int i = 0; i < 600; i++) begin
      logic [AW-1:0] a, b, ed, md;
      bit e1, e2;
      a  = AW'($urandom_range(0, 3));
      b  = AW'($urandom_range(0, 3));
      ed = ($urandom_range(0, 3) == 0) ? AW'($urandom) : AW'($urandom_range(0, 3));
      md = ($urandom_range(0, 3) == 0) ? AW'($urandom) : AW'($urandom_range(0, 3));
      drive(a, b, 1'($urandom), 1'($urandom), ed, 1'($urandom), md);
      e1 = ex_ld && ex_d != 0 && ex_d == src_a;
      e2 = ex_ld && ex_d != 0 && ex_d == src_b;
      if (e1)                                      chk("R1 random", exp_stall());
      else if (e2)                                 chk("R2 random", exp_stall());
      else if (br && ex_rule(src_a, src_b, mem_d, mem_ld)) chk("R3 random", exp_stall());
      else if (!br && ex_rule(src_a, src_b, mem_d, mem_ld)) chk("R4 random", exp_stall());
      else if (ex_d == 0 || mem_d == 0)            chk("R5 random", exp_stall());
      else                                         chk("R6 random", exp_stall());
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule